// File: doc/BRIEF.md
# Input Protection Switch Sequencer

This block decides when an external power pass switch may conduct and when an active-low fault flag may be released. Each cycle it receives a sampled supply-voltage code in millivolts, a sampled die-temperature code in degrees Celsius, and an active-low enable. From these it produces a switch-on command and an active-low fault flag.

Three window detectors watch the inputs: supply too low, supply too high, and die too hot. Each detector has its own hysteresis band. Once all three report good, a settling timer must run out before the switch closes. A second timer, started after the first, must also run out before the fault flag goes high. Any detected fault opens the switch and pulls the flag low in the same cycle, with no register in between. The enable only controls the switch, so the flag keeps reporting supply and temperature status whether the block is enabled or not.

All thresholds, hysteresis widths and delays are parameters. The default delays equal 50 ms at a 250 MHz clock.

Top module: `supply_guard_seq`

## Requirements
- R1: A synchronous reset leaves the switch open (sw_on=0) and the flag asserted (flt_n=0). Every detector starts tripped, and every timer starts at zero, so a full qualification sequence is needed afterwards.
- R2: Undervoltage trips when vin_mv < UV_MV-UV_HYS_MV (3200 by default). Once tripped it clears only when vin_mv > UV_MV (3250). Inside the band between the two, the previous state is held.
- R3: Overvoltage trips when vin_mv > OV_MV. Once tripped it clears only when vin_mv < OV_MV-OV_HYS_MV. Inside the band, the previous state is held.
- R4: Overtemperature trips when temp_c > OT_C. Once tripped it clears only when temp_c < OT_C-OT_HYS_C (20 degrees of hysteresis). Inside the band, the previous state is held.
- R5: When any detector reports a fault, sw_on=0 and flt_n=0 in the same cycle the offending sample is presented.
- R6: With en_n=0, sw_on goes to 1 only after T_ON_CYCLES consecutive cycles in which all detectors report good.
- R7: flt_n goes to 1 only after a further T_START_CYCLES good cycles, counted from the first cycle after the settling timer completes.
- R8: A fault during either delay clears both timers. The full T_ON_CYCLES + T_START_CYCLES sequence then restarts once the conditions are good again.
- R9: en_n=1 forces sw_on=0 in that same cycle and has no effect on flt_n.
- R10: The flag-release timer runs while en_n=1, so flt_n can go high with the switch open. When en_n later returns to 0, sw_on goes to 1 only after T_ON_CYCLES further cycles with en_n=0 and conditions good.
- R11: When vin_mv < VALID_MV (1200 by default), flt_n is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vin_mv | input | VIN_W | Sampled supply voltage, millivolts, unsigned |
| temp_c | input | TEMP_W | Sampled die temperature, degrees Celsius, unsigned |
| en_n | input | 1 | Active-low enable for the switch |
| sw_on | output | 1 | Pass switch command, 1 = conduct |
| flt_n | output | 1 | Fault flag, 0 = fault reported |

## Verification
The hardest situations to reach are the hysteresis bands. There, the same input value must give opposite verdicts depending on history, so the stimulus approaches each band from both sides: once from the good region, where the switch must stay closed, and once just after a trip, where it must stay open. The second hard area is the interplay between the two chained timers and the enable. The stimulus therefore injects a single-cycle fault in the middle of each delay, and holds the enable high across a complete flag release before dropping it. A cycle-accurate expectation model in the driver predicts both outputs for every cycle of these sequences.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
    // Which side of the threshold is the unsafe one.
    typedef enum logic {
        SIDE_LOW  = 1'b0,
        SIDE_HIGH = 1'b1
    } limit_side_e;
endpackage

// File: rtl/hyst_detect.sv
module hyst_detect
    import supply_guard_pkg::*;
#(
    parameter int          W     = 16,
    parameter limit_side_e SIDE  = SIDE_LOW,
    parameter int          TRIP  = 3200,
    parameter int          CLEAR = 3250
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    output logic         bad
);
    localparam logic [W-1:0] TRIP_L  = W'(TRIP);
    localparam logic [W-1:0] CLEAR_L = W'(CLEAR);

    typedef struct packed {
        logic tripped;
    } hd_state_t;

    hd_state_t st_d, st_q;
    logic trip_now, clear_now;

    generate
        if (SIDE == SIDE_HIGH) begin : g_high
            assign trip_now  = level > TRIP_L;
            assign clear_now = level < CLEAR_L;
        end else begin : g_low
            assign trip_now  = level < TRIP_L;
            assign clear_now = level > CLEAR_L;
        end
    endgenerate

    always_comb begin
        bad         = st_q.tripped ? !clear_now : trip_now;
        st_d        = st_q;
        st_d.tripped = bad;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.tripped <= 1'b1;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_L = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dt_state_t;

    dt_state_t st_d, st_q;

    always_comb begin
        done = (st_q.cnt == LIMIT_L);
        st_d = st_q;
        if (clear)             st_d.cnt = '0;
        else if (run && !done) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.cnt <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
    import supply_guard_pkg::*;
#(
    parameter int VIN_W          = 16,
    parameter int TEMP_W         = 8,
    parameter int UV_MV          = 3250,
    parameter int UV_HYS_MV      = 50,
    parameter int OV_MV          = 6000,
    parameter int OV_HYS_MV      = 300,
    parameter int OT_C           = 125,
    parameter int OT_HYS_C       = 20,
    parameter int VALID_MV       = 1200,
    parameter int T_ON_CYCLES    = 12_500_000,
    parameter int T_START_CYCLES = 12_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VIN_W-1:0]  vin_mv,
    input  logic [TEMP_W-1:0] temp_c,
    input  logic              en_n,
    output logic              sw_on,
    output logic              flt_n
);
    localparam logic [VIN_W-1:0] VALID_L = VIN_W'(VALID_MV);

    logic uv_bad, ov_bad, ot_bad;
    logic all_good;
    logic settle_done, close_done, release_done;

    hyst_detect #(.W(VIN_W), .SIDE(SIDE_LOW),
                  .TRIP(UV_MV - UV_HYS_MV), .CLEAR(UV_MV)) uv_det_i (
        .clk(clk), .rst(rst), .level(vin_mv), .bad(uv_bad));

    hyst_detect #(.W(VIN_W), .SIDE(SIDE_HIGH),
                  .TRIP(OV_MV), .CLEAR(OV_MV - OV_HYS_MV)) ov_det_i (
        .clk(clk), .rst(rst), .level(vin_mv), .bad(ov_bad));

    hyst_detect #(.W(TEMP_W), .SIDE(SIDE_HIGH),
                  .TRIP(OT_C), .CLEAR(OT_C - OT_HYS_C)) ot_det_i (
        .clk(clk), .rst(rst), .level(temp_c), .bad(ot_bad));

    always_comb all_good = !(uv_bad || ov_bad || ot_bad);

    // Qualifies the conditions; gates the flag-release timer.
    dwell_timer #(.LIMIT(T_ON_CYCLES)) settle_tmr_i (
        .clk(clk), .rst(rst), .clear(!all_good), .run(1'b1), .done(settle_done));

    // Own settling window for the switch, restarted by the enable.
    dwell_timer #(.LIMIT(T_ON_CYCLES)) close_tmr_i (
        .clk(clk), .rst(rst), .clear(!all_good || en_n), .run(1'b1), .done(close_done));

    dwell_timer #(.LIMIT(T_START_CYCLES)) release_tmr_i (
        .clk(clk), .rst(rst), .clear(!all_good), .run(settle_done), .done(release_done));

    // Output gating is combinational so a fault acts in the sample cycle.
    always_comb begin
        sw_on = close_done && all_good && !en_n;
        flt_n = release_done && all_good && (vin_mv >= VALID_L);
    end
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
    parameter int VIN_W    = 16,
    parameter int TEMP_W   = 8,
    parameter int OV_MV    = 6000,
    parameter int OT_C     = 125,
    parameter int VALID_MV = 1200
) (
    input logic              clk,
    input logic              rst,
    input logic [VIN_W-1:0]  vin_mv,
    input logic [TEMP_W-1:0] temp_c,
    input logic              en_n,
    input logic              sw_on,
    input logic              flt_n
);
    logic rst_prev_q;
    always_ff @(posedge clk) rst_prev_q <= rst;

    assert_reset_open_R1: assert property (@(posedge clk) disable iff (rst)
        rst_prev_q |-> (!sw_on && !flt_n));

    assert_ov_immediate_R5: assert property (@(posedge clk) disable iff (rst)
        (vin_mv > VIN_W'(OV_MV)) |-> (!sw_on && !flt_n));

    assert_ot_immediate_R4: assert property (@(posedge clk) disable iff (rst)
        (temp_c > TEMP_W'(OT_C)) |-> (!sw_on && !flt_n));

    assert_enable_opens_R9: assert property (@(posedge clk) disable iff (rst)
        en_n |-> !sw_on);

    assert_low_supply_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (vin_mv < VIN_W'(VALID_MV)) |-> !flt_n);

    assert_close_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_on) |-> $past(!en_n));
endmodule

bind supply_guard_seq supply_guard_chk #(
    .VIN_W(VIN_W), .TEMP_W(TEMP_W), .OV_MV(OV_MV), .OT_C(OT_C), .VALID_MV(VALID_MV)
) chk_i (
    .clk(clk), .rst(rst), .vin_mv(vin_mv), .temp_c(temp_c),
    .en_n(en_n), .sw_on(sw_on), .flt_n(flt_n)
);

// File: tb/supply_guard_seq_tb_top.sv
`timescale 1ns/1ps
module supply_guard_seq_tb_top;
    localparam int UV = 3250, UVH = 50, OV = 6000, OVH = 300;
    localparam int OT = 125, OTH = 20, VALID = 1200, TON = 20, TST = 30;

    logic clk = 1'b0, rst = 1'b1;
    logic [15:0] vin = '0;
    logic [7:0]  temp = '0;
    logic en_n = 1'b1;
    logic sw_on, flt_n;

    always #2 clk = ~clk;

    supply_guard_seq #(
        .UV_MV(UV), .UV_HYS_MV(UVH), .OV_MV(OV), .OV_HYS_MV(OVH),
        .OT_C(OT), .OT_HYS_C(OTH), .VALID_MV(VALID),
        .T_ON_CYCLES(TON), .T_START_CYCLES(TST)
    ) dut_i (
        .clk(clk), .rst(rst), .vin_mv(vin), .temp_c(temp), .en_n(en_n),
        .sw_on(sw_on), .flt_n(flt_n));

    typedef struct {
        logic  sw;
        logic  flt;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // expectation model state (reset values from R1)
    bit m_uv = 1, m_ov = 1, m_ot = 1;
    int m_q = 0, m_s = 0, m_r = 0;

    task automatic step(input int v, input int t, input logic e, input string tag);
        bit uvb, ovb, otb, good;
        exp_t it;
        @(negedge clk);
        vin = 16'(v); temp = 8'(t); en_n = e;
        uvb = m_uv ? !(v > UV) : (v < UV - UVH);
        ovb = m_ov ? !(v < OV - OVH) : (v > OV);
        otb = m_ot ? !(t < OT - OTH) : (t > OT);
        good = !(uvb || ovb || otb);
        it.sw = (m_s == TON) && good && !e;
        it.flt = (m_r == TST) && good && (v >= VALID);
        it.tag = tag;
        q.push_back(it);
        m_uv = uvb; m_ov = ovb; m_ot = otb;
        m_r = !good ? 0 : ((m_q == TON && m_r < TST) ? m_r + 1 : m_r);
        m_q = !good ? 0 : (m_q < TON ? m_q + 1 : m_q);
        m_s = (!good || e) ? 0 : (m_s < TON ? m_s + 1 : m_s);
    endtask

    task automatic run(input int n, input int v, input int t, input logic e, input string tag);
        for (int i = 0; i < n; i++) step(v, t, e, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk); #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_cmp++;
                if (sw_on !== it.sw || flt_n !== it.flt) begin
                    n_bad++;
                    $display("FAIL %s: sw_on=%b flt_n=%b expected sw_on=%b flt_n=%b at %0t",
                             it.tag, sw_on, flt_n, it.sw, it.flt, $time);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: after reset nothing closes early; R6/R7 full sequence
        run(5, 5000, 25, 1'b0, "R1 reset state");
        run(60, 5000, 25, 1'b0, "R6 R7 startup sequence");
        // R2 undervoltage hysteresis
        run(5, 3220, 25, 1'b0, "R2 band from good side holds");
        run(2, 3199, 25, 1'b0, "R2 trip R5 immediate");
        run(30, 3230, 25, 1'b0, "R2 band after trip stays off");
        run(3, 3250, 25, 1'b0, "R2 equal threshold not enough");
        run(60, 3251, 25, 1'b0, "R2 recovery");
        // R3 overvoltage hysteresis
        run(3, 5900, 25, 1'b0, "R3 band from good side holds");
        run(2, 6001, 25, 1'b0, "R3 trip R5 immediate");
        run(30, 5800, 25, 1'b0, "R3 band after trip stays off");
        run(60, 5699, 25, 1'b0, "R3 recovery");
        // R4 overtemperature hysteresis
        run(3, 5000, 120, 1'b0, "R4 band from good side holds");
        run(2, 5000, 126, 1'b0, "R4 trip R5 immediate");
        run(30, 5000, 105, 1'b0, "R4 band after trip stays off");
        run(60, 5000, 104, 1'b0, "R4 recovery");
        // R8 fault during each delay
        run(1, 6500, 25, 1'b0, "R8 fault");
        run(10, 5000, 25, 1'b0, "R8 partial settle");
        run(1, 5000, 130, 1'b0, "R8 fault in settle");
        run(25, 5000, 25, 1'b0, "R8 into release wait");
        run(1, 3000, 25, 1'b0, "R8 fault in release wait");
        run(60, 5000, 25, 1'b0, "R8 restart");
        // R9 enable
        run(5, 5000, 25, 1'b1, "R9 enable high opens, flag kept");
        run(30, 5000, 25, 1'b0, "R9 R10 reclose after delay");
        // R10 release with enable high
        run(1, 6500, 25, 1'b1, "R10 fault");
        run(60, 5000, 25, 1'b1, "R10 flag clears with switch open");
        run(25, 5000, 25, 1'b0, "R10 switch own delay");
        // R11 low supply
        run(3, 1000, 25, 1'b0, "R11 flag held low");
        run(2, 5000, 25, 1'b0, "R11 no early recovery");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule